// File: doc/BRIEF.md
# Prescaled Match Timer

A register-mapped timer peripheral. It has a prescale stage, an up-counter and one compare channel. The prescale stage divides the input clock by a programmable ratio. Each prescale wrap advances the counter by one. When the counter holds the compare value on one of those advances, the block carries out the actions that software has armed. There are three actions: raise an interrupt flag, return the counter to zero, or halt the counter by clearing its own run bit.

A blocking delay is built by arming the halt action and starting the timer. Software then polls the run bit until it reads back as zero. A periodic tick is built by arming the zero-return and interrupt actions instead. Software acknowledges each tick by writing a one to the flag register.

Access goes through a plain synchronous bus: word address, write strobe, write data and read data registered one cycle after the address. The register map uses word addresses:
- 0: control. Bit 0 is run; bit 1 is hold-clear.
- 1: divide ratio.
- 2: compare value.
- 3: action enables. Bit 0 is interrupt, bit 1 is zero-return, bit 2 is halt.
- 4: flag. Bit 0 is the pending match flag.

Top module: `match_timer`

## Requirements
- R1: After reset every register reads as zero and `irq` is low.
- R2: While control bit 1 is set, the prescale and main counters are held at zero and no match can occur, even with bit 0 set. Clearing bit 1 restarts counting from zero.
- R3: With divide ratio P, the counter advances once every P+1 clocks. With compare value M and the counter starting from zero, the first match lands exactly (M+1)(P+1) clocks after the edge that writes control = 0x1.
- R4: A match sets flag bit 0 only when action bit 0 is set. `irq` is high exactly while flag bit 0 is set.
- R5: With action bit 1 set, the counter returns to zero on a match, so matches repeat every (M+1)(P+1) clocks.
- R6: Without action bit 1, the counter runs past the compare value and wraps from all-ones to zero. The next match therefore comes 2^CNT_W advances later.
- R7: With action bit 2 set, a match clears control bit 0, and reads return it as zero. The counter keeps the compare value, so a restart without a clear matches again after P+1 clocks.
- R8: Writing a one to flag bit 0 (for example 0xFF) clears it, and writing zero leaves it unchanged. A match in the same cycle as a clearing write leaves the flag set.
- R9: Reads return data one cycle after the address. Fields narrower than the bus read back truncated, and unused bits read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Word address of the register |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Pending match interrupt |

## Verification
The bench builds the timer with an 8-bit counter and an 8-bit divide ratio (CNT_W = 8, PS_W = 8). With these widths, a full counter wrap after a missed compare value (R6) completes within a few hundred clocks. Wide write values also show their upper bits dropped on read-back. Every match instant is predicted from the (M+1)(P+1) rule, including a flag clear that lands in the same cycle as a match.

// File: rtl/mt_pkg.sv
package mt_pkg;
  localparam int unsigned BUS_W  = 32;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL  = 3'd0,
    A_DIV   = 3'd1,
    A_CMP   = 3'd2,
    A_ACT   = 3'd3,
    A_FLAG  = 3'd4
  } reg_addr_e;

  localparam int unsigned CTRL_RUN = 0;
  localparam int unsigned CTRL_CLR = 1;
  localparam int unsigned ACT_IRQ  = 0;
  localparam int unsigned ACT_ZERO = 1;
  localparam int unsigned ACT_HALT = 2;
  localparam int unsigned ACT_W    = 3;
endpackage

// File: rtl/mt_prescaler.sv
module mt_prescaler #(
  parameter int unsigned PS_W = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  input  logic            clr,
  input  logic [PS_W-1:0] limit,
  output logic            tick
);
  logic [PS_W-1:0] pc;
  logic            at_end;

  assign at_end = (pc >= limit);
  assign tick   = run && !clr && at_end;

  always_ff @(posedge clk) begin
    if (rst || clr)   pc <= '0;
    else if (run) begin
      if (at_end)     pc <= '0;
      else            pc <= pc + 1'b1;
    end
  end

  assert_clr_hold_R2: assert property (@(posedge clk) disable iff (rst)
    clr |=> (pc == '0));

  assert_wrap_R3: assert property (@(posedge clk) disable iff (rst)
    (run && !clr && at_end) |=> (pc == '0));
endmodule

// File: rtl/mt_counter.sv
module mt_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             tick,
  input  logic [CNT_W-1:0] cmp,
  input  logic             zero_on_hit,
  input  logic             halt_on_hit,
  output logic             hit
);
  logic [CNT_W-1:0] tc;

  assign hit = tick && (tc == cmp);

  always_ff @(posedge clk) begin
    if (rst || clr)               tc <= '0;
    else if (hit && zero_on_hit)  tc <= '0;
    else if (hit && halt_on_hit)  tc <= tc;
    else if (tick)                tc <= tc + 1'b1;
  end

  assert_zero_hit_R5: assert property (@(posedge clk) disable iff (rst)
    (hit && zero_on_hit) |=> (tc == '0));

  assert_halt_keep_R7: assert property (@(posedge clk) disable iff (rst)
    (hit && halt_on_hit && !zero_on_hit && !clr) |=> (tc == $past(tc)));
endmodule

// File: rtl/match_timer.sv
module match_timer
  import mt_pkg::*;
#(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned PS_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              irq
);
  logic             run, clr, flag;
  logic [PS_W-1:0]  div_r;
  logic [CNT_W-1:0] cmp_r;
  logic [ACT_W-1:0] act_r;
  logic             tick, hit;
  logic             wr_ctrl, wr_flag;

  assign wr_ctrl = bus_we && (bus_addr == A_CTRL);
  assign wr_flag = bus_we && (bus_addr == A_FLAG);

  always_ff @(posedge clk) begin
    if (rst) begin
      run   <= 1'b0;
      clr   <= 1'b0;
      div_r <= '0;
      cmp_r <= '0;
      act_r <= '0;
    end else begin
      if (wr_ctrl) begin
        run <= bus_wdata[CTRL_RUN];
        clr <= bus_wdata[CTRL_CLR];
      end else if (hit && act_r[ACT_HALT]) begin
        run <= 1'b0;
      end
      if (bus_we && bus_addr == A_DIV) div_r <= bus_wdata[PS_W-1:0];
      if (bus_we && bus_addr == A_CMP) cmp_r <= bus_wdata[CNT_W-1:0];
      if (bus_we && bus_addr == A_ACT) act_r <= bus_wdata[ACT_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) flag <= 1'b0;
    else     flag <= (flag && !(wr_flag && bus_wdata[0])) || (hit && act_r[ACT_IRQ]);
  end

  assign irq = flag;

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else begin
      case (bus_addr)
        A_CTRL:  bus_rdata <= BUS_W'({clr, run});
        A_DIV:   bus_rdata <= BUS_W'(div_r);
        A_CMP:   bus_rdata <= BUS_W'(cmp_r);
        A_ACT:   bus_rdata <= BUS_W'(act_r);
        A_FLAG:  bus_rdata <= BUS_W'(flag);
        default: bus_rdata <= '0;
      endcase
    end
  end

  mt_prescaler #(.PS_W(PS_W)) u_pre (
    .clk   (clk),
    .rst   (rst),
    .run   (run),
    .clr   (clr),
    .limit (div_r),
    .tick  (tick)
  );

  mt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk         (clk),
    .rst         (rst),
    .clr         (clr),
    .tick        (tick),
    .cmp         (cmp_r),
    .zero_on_hit (act_r[ACT_ZERO]),
    .halt_on_hit (act_r[ACT_HALT]),
    .hit         (hit)
  );

  assert_flag_set_R4: assert property (@(posedge clk) disable iff (rst)
    (hit && act_r[ACT_IRQ]) |=> flag);

  assert_no_flag_R4: assert property (@(posedge clk) disable iff (rst)
    (!flag && !(hit && act_r[ACT_IRQ])) |=> !flag);

  assert_halt_run_R7: assert property (@(posedge clk) disable iff (rst)
    (hit && act_r[ACT_HALT] && !wr_ctrl) |=> !run);

  assert_clear_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_flag && bus_wdata[0] && !hit) |=> !flag);
endmodule

// File: tb/sim_match_timer.sv
module sim_match_timer;
  localparam int CLK_P = 10;
  localparam int CW    = 8;
  localparam int PW    = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [31:0] exp_d[$];
  string       exp_tag[$];
  logic        rd_req = 1'b0;
  logic        rd_req_d = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  match_timer #(.CNT_W(CW), .PS_W(PW)) u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  always @(posedge clk) rd_req_d <= rd_req;

  // monitor: compares read data against the scoreboard queue
  always @(negedge clk) begin
    if (rd_req_d && exp_d.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_d.pop_front();
      t = exp_tag.pop_front();
      n_vec++;
      if (bus_rdata !== e) begin
        n_bad++;
        $display("FAIL %s read: actual %h expected %h", t, bus_rdata, e);
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] e, input string t);
    bus_addr = a; rd_req = 1'b1;
    exp_d.push_back(e); exp_tag.push_back(t);
    @(negedge clk);
    rd_req = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    n_vec++;
    if (irq !== e) begin
      n_bad++;
      $display("FAIL %s irq: actual %b expected %b", t, irq, e);
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    step(3);
    rst = 1'b0;
    step(1);
    // R1 reset state
    chk_irq(1'b0, "R1");
    for (int a = 0; a < 5; a++) rd(3'(a), 32'h0, "R1");

    // R9 truncation and unused bits
    wr(3'd1, 32'hFFFF_FF03);  rd(3'd1, 32'h03, "R9");
    wr(3'd2, 32'h1234_56AB);  rd(3'd2, 32'hAB, "R9");
    wr(3'd3, 32'hFFFF_FFFF);  rd(3'd3, 32'h7, "R9");
    wr(3'd0, 32'hFFFF_FFFC);  rd(3'd0, 32'h0, "R9");

    // R3 + R4 + R7: P=2, M=4, interrupt + halt
    wr(3'd1, 32'd2); wr(3'd2, 32'd4); wr(3'd3, 32'h5);
    wr(3'd0, 32'h1);
    step(14); chk_irq(1'b0, "R3");
    step(1);  chk_irq(1'b1, "R3");
    rd(3'd0, 32'h0, "R7");
    wr(3'd4, 32'h0); chk_irq(1'b1, "R8");
    wr(3'd4, 32'hFF); chk_irq(1'b0, "R8");
    // R7 restart without clear: match after P+1 clocks
    wr(3'd0, 32'h1);
    step(2); chk_irq(1'b0, "R7");
    step(1); chk_irq(1'b1, "R7");

    // R2 hold-clear
    wr(3'd4, 32'h1);
    wr(3'd0, 32'h3);
    step(10); chk_irq(1'b0, "R2");
    rd(3'd0, 32'h3, "R2");
    wr(3'd0, 32'h1);
    step(14); chk_irq(1'b0, "R2");
    step(1);  chk_irq(1'b1, "R2");

    // R5 periodic zero-return, plus R8 collision
    wr(3'd0, 32'h2); wr(3'd4, 32'h1);
    wr(3'd3, 32'h3); wr(3'd1, 32'd0); wr(3'd2, 32'd4);
    wr(3'd0, 32'h1);
    step(5); chk_irq(1'b1, "R5");
    wr(3'd4, 32'h1); chk_irq(1'b0, "R8");
    step(3); chk_irq(1'b0, "R5");
    step(1); chk_irq(1'b1, "R5");
    step(4);
    wr(3'd4, 32'h1); chk_irq(1'b1, "R8");
    wr(3'd4, 32'h1); chk_irq(1'b0, "R8");

    // R6 wrap without zero-return
    wr(3'd0, 32'h2); wr(3'd4, 32'h1);
    wr(3'd3, 32'h1); wr(3'd2, 32'd3);
    wr(3'd0, 32'h1);
    step(4); chk_irq(1'b1, "R6");
    wr(3'd4, 32'h1); chk_irq(1'b0, "R6");
    step(254); chk_irq(1'b0, "R6");
    step(1);   chk_irq(1'b1, "R6");

    // R4 halt without interrupt; R7 run bit polled
    wr(3'd0, 32'h2); wr(3'd4, 32'h1);
    wr(3'd3, 32'h4); wr(3'd1, 32'd1); wr(3'd2, 32'd2);
    wr(3'd0, 32'h1);
    step(2); rd(3'd0, 32'h1, "R7");
    step(8); rd(3'd0, 32'h0, "R7");
    chk_irq(1'b0, "R4");
    rd(3'd4, 32'h0, "R4");

    step(2);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule